// File: doc/BRIEF.md
# Codec Two-Wire Configuration Write Sequencer

After reset, this block programs an audio codec with a fixed set of register writes over a two-wire serial bus. No outside command starts it. A command ROM holds the write list. A setup sequencer steps through that list one entry at a time. A bit-level protocol engine turns each entry into a bus transaction with these parts, in order:

- a START condition
- the device write address byte
- two command bytes
- an acknowledge slot after each byte
- a STOP condition

The protocol engine moves only on ticks from a clock divider. A request that lasts only one system cycle could fall between ticks and be lost. For that reason the sequencer keeps its request raised until the engine accepts it on a tick.

SCL is driven directly from the engine state. SDA is driven open-drain: the engine only pulls it low or releases it, and it reads the line back for acknowledges. Both 4-bit state machines are brought out for debug lamps. If the codec does not acknowledge a byte, the block ends the transaction with a STOP, halts the setup and sets a sticky error flag.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is asserted and directly after it, `scl_o` is 1, `sda_pull_o` is 0, `xfer_done_o`, `error_o` and `setup_done_o` are 0, and both `seq_state_o` and `eng_state_o` read 0.
- R2: The sequencer keeps its send request raised until the engine accepts it, and the engine accepts only on a divider tick. As a result, every command in the list reaches the bus even though a tick comes only once per TICK_DIV cycles.
- R3: Each command is sent as one transaction in this order: START, the write address byte 0x34, then cmd[15:8], then cmd[7:0], then STOP. Each 16-bit command is {reg[6:0], data[8:0]}. The commands are sent in list order with these (reg, data) pairs: (0x0F,0x000) reset, (0x06,0x000) power, (0x07,0x00A) format, (0x08,0x000) sampling, (0x04,0x012) analog path, (0x09,0x001) activate.
- R4: Bytes go out MSB first. SDA changes only while SCL is low. The two exceptions are START, where SDA falls while SCL is high, and STOP, where SDA rises while SCL is high.
- R5: `xfer_done_o` goes high for exactly one system cycle for each fully acknowledged transaction. The sequencer moves on to the next command only after this pulse.
- R6: After the last command's pulse, `setup_done_o` rises and stays high. At that point `seq_state_o` reads 3, `eng_state_o` reads 0 (idle), and the bus is idle with SCL high and SDA released.
- R7: If the slave does not acknowledge a byte (SDA high in its acknowledge slot), the engine sends a STOP and sets `error_o`. The error stays set until reset. The sequencer halts with `seq_state_o` at 4, `setup_done_o` stays 0, and no further START appears.
- R8: One SCL bit period lasts 4*TICK_DIV system cycles, and SCL is high for 2*TICK_DIV cycles of it.
- R9: If the missing acknowledge falls on the final byte of the final command, the error takes priority. That transaction gives no `xfer_done_o` pulse, and `setup_done_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Level read back from the SDA line |
| scl_o | output | 1 | Serial clock |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| xfer_done_o | output | 1 | One-cycle pulse when a command has been sent and acknowledged |
| error_o | output | 1 | Sticky flag for a missing acknowledge |
| setup_done_o | output | 1 | High once the whole list has been written |
| seq_state_o | output | 4 | Sequencer state: 0 boot, 1 request, 2 wait, 3 done, 4 halted |
| eng_state_o | output | 4 | Engine state: 0 idle, 1 start, 2 start hold, 3 data, 4 ack, 5-7 stop steps |

## Verification
Completion of the final transaction and detection of a missing acknowledge are decided at the same point: the end of the STOP on the last command. Here the engine must choose between a done pulse, which would let the sequencer finish setup, and a failure, which must halt it. The bench provokes this with a slave model that refuses to acknowledge the eighteenth byte, which is the last byte of the last command. It then checks that five done pulses were seen, that the error flag is set, that the setup-done flag never rose, and that the sequencer reads halted. Separate runs place the missing acknowledge on the very first address byte and in the middle of the list, to show that the abort works at any position.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   localparam logic [7:0] DEV_WR_ADDR = 8'h34;
   localparam int CMD_W       = 16;
   localparam int TABLE_LEN   = 6;

   typedef enum logic [3:0] {
      E_IDLE      = 4'd0,
      E_START     = 4'd1,
      E_START_HLD = 4'd2,
      E_DATA      = 4'd3,
      E_ACK       = 4'd4,
      E_STOP_LOW  = 4'd5,
      E_STOP_HIGH = 4'd6,
      E_STOP_REL  = 4'd7
   } eng_state_t;

   typedef enum logic [3:0] {
      S_BOOT = 4'd0,
      S_REQ  = 4'd1,
      S_WAIT = 4'd2,
      S_DONE = 4'd3,
      S_HALT = 4'd4
   } seq_state_t;

   // command = {register index (7 bits), register payload (9 bits)}
   function automatic logic [CMD_W-1:0] cmd_entry(input int unsigned i);
      logic [6:0] r;
      logic [8:0] d;
      case (i)
         0:       begin r = 7'h0F; d = 9'h000; end   // soft reset
         1:       begin r = 7'h06; d = 9'h000; end   // power everything up
         2:       begin r = 7'h07; d = 9'h00A; end   // serial audio format
         3:       begin r = 7'h08; d = 9'h000; end   // sampling control
         4:       begin r = 7'h04; d = 9'h012; end   // analog routing
         5:       begin r = 7'h09; d = 9'h001; end   // interface activate
         default: begin r = 7'h00; d = 9'h000; end
      endcase
      return {r, d};
   endfunction

endpackage

// File: rtl/cfgseq_tick_gen.sv
module cfgseq_tick_gen #(
   parameter int TICK_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   if (TICK_DIV < 4) begin : g_bad_div
      $error("TICK_DIV must be at least 4");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt == LAST)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/cfgseq_cmd_rom.sv
module cfgseq_cmd_rom
   import cfgseq_pkg::*;
#(
   parameter int NUM_CMDS = 6,
   parameter int IW       = 3
) (
   input  logic [IW-1:0]    idx,
   output logic [CMD_W-1:0] cmd
);
   localparam int SLOTS = 1 << IW;

   if (NUM_CMDS < 1 || NUM_CMDS > TABLE_LEN) begin : g_bad_len
      $error("NUM_CMDS outside the command list");
   end
   if (SLOTS < NUM_CMDS) begin : g_bad_iw
      $error("IW too narrow for NUM_CMDS");
   end

   logic [CMD_W-1:0] table_q [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      if (k < NUM_CMDS) begin : g_used
         assign table_q[k] = cmd_entry(k);
      end else begin : g_pad
         assign table_q[k] = '0;
      end
   end

   assign cmd = table_q[idx];

endmodule

// File: rtl/cfgseq_bit_engine.sv
module cfgseq_bit_engine
   import cfgseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             req,
   input  logic [CMD_W-1:0] cmd,
   input  logic             sda_i,
   output logic             accept,
   output logic             done,
   output logic             fail,
   output logic             err,
   output logic             scl_o,
   output logic             sda_pull,
   output logic [3:0]       state_o
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..4");
   end

   // read-back synchroniser variant
   logic sda_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_s = sda_i;
   end else begin : g_sync
      logic chain [SYNC_STAGES];
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_st
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= sda_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
      assign sda_s = chain[SYNC_STAGES-1];
   end

   eng_state_t       state;
   logic [1:0]       phase;
   logic [2:0]       bit_cnt;
   logic [1:0]       byte_cnt;
   logic [7:0]       shreg;
   logic [CMD_W-1:0] frame;
   logic             nack;

   assign accept = tick && (state == E_IDLE) && req && !err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= E_IDLE;
         phase    <= '0;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         shreg    <= '0;
         frame    <= '0;
         nack     <= 1'b0;
         err      <= 1'b0;
         done     <= 1'b0;
         fail     <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         if (tick) begin
            case (state)
               E_IDLE: if (accept) begin
                  frame    <= cmd;
                  shreg    <= DEV_WR_ADDR;
                  byte_cnt <= 2'd0;
                  bit_cnt  <= 3'd7;
                  phase    <= 2'd0;
                  nack     <= 1'b0;
                  state    <= E_START;
               end
               E_START:     state <= E_START_HLD;
               E_START_HLD: state <= E_DATA;
               E_DATA: begin
                  if (phase == 2'd3) begin
                     phase <= 2'd0;
                     if (bit_cnt == 3'd0) begin
                        state <= E_ACK;
                     end else begin
                        bit_cnt <= bit_cnt - 3'd1;
                        shreg   <= {shreg[6:0], 1'b0};
                     end
                  end else begin
                     phase <= phase + 2'd1;
                  end
               end
               E_ACK: begin
                  if (phase == 2'd2) nack <= sda_s;
                  if (phase == 2'd3) begin
                     phase <= 2'd0;
                     if (nack || byte_cnt == 2'd2) begin
                        state <= E_STOP_LOW;
                     end else begin
                        byte_cnt <= byte_cnt + 2'd1;
                        bit_cnt  <= 3'd7;
                        shreg    <= (byte_cnt == 2'd0) ? frame[15:8] : frame[7:0];
                        state    <= E_DATA;
                     end
                  end else begin
                     phase <= phase + 2'd1;
                  end
               end
               E_STOP_LOW:  state <= E_STOP_HIGH;
               E_STOP_HIGH: state <= E_STOP_REL;
               E_STOP_REL: begin
                  state <= E_IDLE;
                  if (nack) begin
                     err  <= 1'b1;
                     fail <= 1'b1;
                  end else begin
                     done <= 1'b1;
                  end
               end
               default: state <= E_IDLE;
            endcase
         end
      end
   end

   // line decode: SCL high in the middle two quarters of a bit
   always_comb begin
      scl_o    = 1'b1;
      sda_pull = 1'b0;
      case (state)
         E_IDLE:      begin scl_o = 1'b1; sda_pull = 1'b0; end
         E_START:     begin scl_o = 1'b1; sda_pull = 1'b1; end
         E_START_HLD: begin scl_o = 1'b0; sda_pull = 1'b1; end
         E_DATA:      begin scl_o = (phase == 2'd1) || (phase == 2'd2); sda_pull = ~shreg[7]; end
         E_ACK:       begin scl_o = (phase == 2'd1) || (phase == 2'd2); sda_pull = 1'b0; end
         E_STOP_LOW:  begin scl_o = 1'b0; sda_pull = 1'b1; end
         E_STOP_HIGH: begin scl_o = 1'b1; sda_pull = 1'b1; end
         E_STOP_REL:  begin scl_o = 1'b1; sda_pull = 1'b0; end
         default:     begin scl_o = 1'b1; sda_pull = 1'b0; end
      endcase
   end

   assign state_o = state;

   p_accept_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> tick);
   p_scl_moves_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_o) |-> $past(tick));
   p_sda_edge_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) && scl_o && $past(scl_o)
         |-> (state == E_START) || (state == E_STOP_REL));
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   p_done_fail_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

endmodule

// File: rtl/cfgseq_sequencer.sv
module cfgseq_sequencer
   import cfgseq_pkg::*;
#(
   parameter int NUM_CMDS = 6,
   parameter int IW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          done,
   input  logic          fail,
   output logic          send_data,
   output logic [IW-1:0] idx,
   output logic          setup_done,
   output logic [3:0]    state_o
);
   localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CMDS - 1);

   seq_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_BOOT;
         idx   <= '0;
      end else begin
         case (state)
            S_BOOT: state <= S_REQ;
            S_REQ:  if (accept) state <= S_WAIT;
            S_WAIT: begin
               if (fail) begin
                  state <= S_HALT;
               end else if (done) begin
                  if (idx == LAST_IDX) begin
                     state <= S_DONE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= S_REQ;
                  end
               end
            end
            S_DONE:  state <= S_DONE;
            S_HALT:  state <= S_HALT;
            default: state <= S_HALT;
         endcase
      end
   end

   assign send_data  = (state == S_REQ);
   assign setup_done = (state == S_DONE);
   assign state_o    = state;

   p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      send_data && !accept |=> send_data);
   p_advance_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != $past(idx)) |-> $past(done));
   p_setup_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      setup_done |=> setup_done);
   p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HALT) |=> (state == S_HALT));

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
   import cfgseq_pkg::*;
#(
   parameter int TICK_DIV    = 125,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_CMDS    = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_i,
   output logic       scl_o,
   output logic       sda_pull_o,
   output logic       xfer_done_o,
   output logic       error_o,
   output logic       setup_done_o,
   output logic [3:0] seq_state_o,
   output logic [3:0] eng_state_o
);
   localparam int IW = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1;

   logic             tick, send_data, accept, fail;
   logic [IW-1:0]    idx;
   logic [CMD_W-1:0] cmd;

   cfgseq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   cfgseq_cmd_rom #(.NUM_CMDS(NUM_CMDS), .IW(IW)) u_rom (
      .idx(idx), .cmd(cmd));

   cfgseq_sequencer #(.NUM_CMDS(NUM_CMDS), .IW(IW)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .done(xfer_done_o),
      .fail(fail), .send_data(send_data), .idx(idx),
      .setup_done(setup_done_o), .state_o(seq_state_o));

   cfgseq_bit_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .req(send_data), .cmd(cmd),
      .sda_i(sda_i), .accept(accept), .done(xfer_done_o), .fail(fail),
      .err(error_o), .scl_o(scl_o), .sda_pull(sda_pull_o),
      .state_o(eng_state_o));

   p_no_setup_with_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(setup_done_o && error_o));
   p_setup_bus_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      setup_done_o |-> scl_o && !sda_pull_o && (eng_state_o == 4'd0));

endmodule

// File: tb/codec_cfg_seq_tb_top.sv
module codec_cfg_seq_tb_top;
   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       scl_o, sda_pull_o, xfer_done_o, error_o, setup_done_o;
   logic [3:0] seq_state_o, eng_state_o;
   logic       slave_pull = 1'b0;
   wire        sda_line = !(sda_pull_o || slave_pull);

   codec_cfg_seq #(.TICK_DIV(DIV), .SYNC_STAGES(2), .NUM_CMDS(6)) dut_i (
      .clk(clk), .rst_n(rst_n), .sda_i(sda_line), .scl_o(scl_o),
      .sda_pull_o(sda_pull_o), .xfer_done_o(xfer_done_o), .error_o(error_o),
      .setup_done_o(setup_done_o), .seq_state_o(seq_state_o),
      .eng_state_o(eng_state_o));

   int total = 0, bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   // ---- slave model -------------------------------------------------
   int starts, stops, viol, byte_idx, nack_at, bitcnt, rises, falls;
   int rise_t [4];
   int fall_t [4];
   bit in_ack, pend_ack, in_frame, nack_now;
   logic [7:0] sh;
   logic [7:0] got [32];
   int done_pulses, wide_pulses;
   logic prev_done = 1'b0;

   always @(negedge sda_line) if (scl_o === 1'b1) begin
      if (in_frame) viol++;
      starts++; in_frame = 1; bitcnt = 0; in_ack = 0; pend_ack = 0;
   end
   always @(posedge sda_line) if (scl_o === 1'b1 && in_frame) begin
      if (bitcnt > 1) viol++;
      stops++; in_frame = 0; bitcnt = 0;
   end
   always @(posedge scl_o) begin
      if (rises < 4) rise_t[rises] = cyc;
      rises++;
      if (in_frame) begin
         if (in_ack) in_ack = 0;
         else begin
            sh = {sh[6:0], sda_line};
            bitcnt++;
            if (bitcnt == 8) begin
               if (byte_idx < 32) got[byte_idx] = sh;
               nack_now = (byte_idx == nack_at);
               byte_idx++; bitcnt = 0; pend_ack = 1;
            end
         end
      end
   end
   always @(negedge scl_o) begin
      if (falls < 4) fall_t[falls] = cyc;
      falls++;
      if (pend_ack) begin pend_ack = 0; in_ack = 1; slave_pull = !nack_now; end
      else slave_pull = 0;
   end
   always @(posedge clk) begin
      if (xfer_done_o) done_pulses++;
      if (xfer_done_o && prev_done) wide_pulses++;
      prev_done = xfer_done_o;
   end

   // ---- helpers -----------------------------------------------------
   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_cmd(input int i);
      logic [6:0] r; logic [8:0] d;
      case (i)
         0: begin r = 7'h0F; d = 9'h000; end
         1: begin r = 7'h06; d = 9'h000; end
         2: begin r = 7'h07; d = 9'h00A; end
         3: begin r = 7'h08; d = 9'h000; end
         4: begin r = 7'h04; d = 9'h012; end
         default: begin r = 7'h09; d = 9'h001; end
      endcase
      return {r, d};
   endfunction

   task automatic do_reset(input int nack_byte);
      @(negedge clk);
      rst_n = 1'b0;
      starts = 0; stops = 0; viol = 0; byte_idx = 0; bitcnt = 0;
      rises = 0; falls = 0; in_ack = 0; pend_ack = 0; in_frame = 0;
      done_pulses = 0; wide_pulses = 0; slave_pull = 0; nack_at = nack_byte;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (setup_done_o || error_o) break;
      end
      repeat (300) @(negedge clk);
   endtask

   // ---- scenarios ---------------------------------------------------
   task automatic t_reset_state();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(scl_o === 1'b1 && sda_pull_o === 1'b0, "R1 lines in reset", {scl_o, sda_pull_o}, 2'b10);
      check(!xfer_done_o && !error_o && !setup_done_o, "R1 flags in reset",
            {xfer_done_o, error_o, setup_done_o}, 0);
      check(seq_state_o == 4'd0 && eng_state_o == 4'd0, "R1 states in reset",
            {seq_state_o, eng_state_o}, 0);
   endtask

   task automatic t_full_run();
      do_reset(-1);
      wait_end();
      check(setup_done_o === 1'b1, "R6 setup done", setup_done_o, 1);
      check(error_o === 1'b0, "R6 no error", error_o, 0);
      check(starts == 6 && stops == 6, "R2 R3 one transaction per command", starts, 6);
      check(viol == 0, "R4 SDA edge rule", viol, 0);
      check(done_pulses == 6, "R5 done pulse count", done_pulses, 6);
      check(wide_pulses == 0, "R5 pulse one cycle wide", wide_pulses, 0);
      check(byte_idx == 18, "R3 byte count", byte_idx, 18);
      for (int i = 0; i < 6; i++) begin
         logic [15:0] c;
         c = exp_cmd(i);
         check(got[3*i] == 8'h34, "R3 address byte", got[3*i], 8'h34);
         check(got[3*i+1] == c[15:8], "R3 R4 command high byte", got[3*i+1], c[15:8]);
         check(got[3*i+2] == c[7:0], "R3 R4 command low byte", got[3*i+2], c[7:0]);
      end
      check(seq_state_o == 4'd3 && eng_state_o == 4'd0, "R6 debug states",
            {seq_state_o, eng_state_o}, 8'h30);
      check(scl_o === 1'b1 && sda_line === 1'b1, "R6 bus idle", {scl_o, sda_line}, 2'b11);
      repeat (500) @(negedge clk);
      check(setup_done_o === 1'b1 && starts == 6, "R6 done holds", starts, 6);
   endtask

   task automatic t_timing();
      do_reset(-1);
      for (int i = 0; i < 2000 && rises < 4; i++) @(negedge clk);
      check(rise_t[2] - rise_t[1] == 4*DIV, "R8 bit period", rise_t[2] - rise_t[1], 4*DIV);
      check(fall_t[1] - rise_t[0] == 2*DIV, "R8 SCL high width", fall_t[1] - rise_t[0], 2*DIV);
   endtask

   task automatic t_nack(input int at, input int exp_starts, input int exp_done, input string tag);
      do_reset(at);
      wait_end();
      check(error_o === 1'b1, {tag, " error set"}, error_o, 1);
      check(setup_done_o === 1'b0, {tag, " no setup done"}, setup_done_o, 0);
      check(done_pulses == exp_done, {tag, " done pulses"}, done_pulses, exp_done);
      check(starts == exp_starts && stops == exp_starts, {tag, " STOP sent, no retry"}, stops, exp_starts);
      check(seq_state_o == 4'd4, {tag, " sequencer halted"}, seq_state_o, 4);
      repeat (600) @(negedge clk);
      check(error_o === 1'b1 && starts == exp_starts, {tag, " error sticky"}, starts, exp_starts);
   endtask

   initial begin : main
      t_reset_state();
      t_full_run();
      t_timing();
      t_nack(0, 1, 0, "R7 nack on address");
      t_nack(4, 2, 1, "R7 nack mid list");
      t_nack(17, 6, 5, "R9 nack on final byte");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule